// File: doc/BRIEF.md
# Protected Processor Mode Register Pair

This block holds two 8-bit control registers that set processor-mode features of a small microcontroller. Software reaches them over a simple synchronous register bus with an address, write data, a write strobe, a read strobe and read data. A write lands only while an unlock input is high. That input comes from a protect register kept outside this block. When the input is low, every write is dropped.

The first register, at byte address 0x04, carries a software-reset command. Writing a 1 to its bit 3 sends a one-cycle reset request to the reset logic. That bit always reads back as 0. The second register, at byte address 0x05, holds three settings:
- bit 0: flash data-block access enable. The flash rewrite-mode input forces it on.
- bit 2: watchdog action select. Software can set it but not clear it.
- bit 7: memory wait enable.

A small wait generator uses the wait enable to stretch internal RAM and ROM accesses by one cycle.

Top module: `pmode_regs`

## Requirements
- R1: After reset, address 0x04 reads 0x00 and address 0x05 reads 0x08. `soft_rst_req`, `flash_blk_en`, `wdt_rst_sel` and `wait_en` are 0, and `mem_ready` is 1.
- R2: A write while `wr_unlock` is 0 is ignored. Register 0x05 keeps its value and no software-reset request is raised.
- R3: An unlocked write to 0x04 with data bit 3 set raises `soft_rst_req` for exactly the one cycle after the write. Address 0x04 always reads 0x00.
- R4: An unlocked write to 0x05 copies data bit 0 into the flash access enable. The value is seen on `flash_blk_en` and in read bit 0.
- R5: While `flash_rewrite` is 1, `flash_blk_en` and read bit 0 of 0x05 are 1, and writing 0 to that bit does not clear it. After `flash_rewrite` falls, the bit stays 1 until software writes 0 to it.
- R6: Writing 1 to bit 2 of 0x05 sets `wdt_rst_sel` (1 selects reset, 0 selects interrupt). Writing 0 has no effect. Only the reset input clears it.
- R7: Bit 7 of 0x05 drives `wait_en`. Suppose a cycle has `mem_start` and `mem_internal` both high while `wait_en` is 1. Then `mem_ready` is low for exactly the next cycle. In every other case `mem_ready` stays high.
- R8: In reads of 0x05, bit 3 is always 1 and bits 1, 4, 5 and 6 are always 0, whatever was written to them.
- R9: `bus_rdata` shows the addressed register in the same cycle that `bus_rd` is high. It is 0x00 when `bus_rd` is low or the address is neither 0x04 nor 0x05. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| wr_unlock | input | 1 | Write enable from the external protect register |
| flash_rewrite | input | 1 | Flash CPU rewrite mode active |
| mem_start | input | 1 | Memory access start strobe |
| mem_internal | input | 1 | The access targets internal RAM or ROM |
| soft_rst_req | output | 1 | One-cycle software-reset request |
| flash_blk_en | output | 1 | Flash data-block access enable |
| wdt_rst_sel | output | 1 | Watchdog action: 1 = reset, 0 = interrupt |
| wait_en | output | 1 | Memory wait state enabled |
| mem_ready | output | 1 | Low for one wait cycle on a stretched access |

## Verification
A corrupted bit of register 0x05 shows up at once on its dedicated output (`flash_blk_en`, `wdt_rst_sel` or `wait_en`). It also shows in the very next read of 0x05, because read data is combinational. A stuck wait flag shows in the cycle after a memory start, as `mem_ready` staying low too long or never dropping. A wrongly held reset pulse shows as `soft_rst_req` still high one cycle after the write. Random writes, with the unlock input toggled at random, are compared against a model after every operation. This exposes lost, extra or unprotected updates within one transaction.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    localparam int DATA_W = 8;

    // bit positions decoded by neighbouring logic
    localparam int SRST_BIT  = 3;
    localparam int FBLK_BIT  = 0;
    localparam int WDT_BIT   = 2;
    localparam int WAIT_BIT  = 7;
    localparam int FIXED_BIT = 3;

    localparam logic [DATA_W-1:0] REG0_RST = 8'h00;

    typedef struct packed {
        logic wait_on;
        logic wdt_reset;
        logic flash_blk;
    } mode1_t;

    localparam mode1_t MODE1_RST = '{wait_on: 1'b0, wdt_reset: 1'b0, flash_blk: 1'b0};

    function automatic logic [DATA_W-1:0] mode1_pack(input mode1_t m);
        logic [DATA_W-1:0] v;
        v            = '0;
        v[FIXED_BIT] = 1'b1;
        v[FBLK_BIT]  = m.flash_blk;
        v[WDT_BIT]   = m.wdt_reset;
        v[WAIT_BIT]  = m.wait_on;
        return v;
    endfunction

endpackage

// File: rtl/pmode_softrst.sv
module pmode_softrst (
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic cmd_bit,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= wr_hit & cmd_bit;
    end
endmodule

// File: rtl/pmode_mode1.sv
module pmode_mode1
    import pmode_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_hit,
    input  mode1_t wr_val,
    input  logic   force_blk,
    output mode1_t state
);
    mode1_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= MODE1_RST;
        end else begin
            if (force_blk)   q.flash_blk <= 1'b1;
            else if (wr_hit) q.flash_blk <= wr_val.flash_blk;
            if (wr_hit) begin
                q.wait_on   <= wr_val.wait_on;
                q.wdt_reset <= q.wdt_reset | wr_val.wdt_reset;
            end
        end
    end

    always_comb begin
        state           = q;
        state.flash_blk = q.flash_blk | force_blk;
    end
endmodule

// File: rtl/pmode_waitgen.sv
module pmode_waitgen (
    input  logic clk,
    input  logic rst,
    input  logic wait_on,
    input  logic mem_start,
    input  logic mem_internal,
    output logic mem_ready
);
    logic stall_q;

    always_ff @(posedge clk) begin
        if (rst) stall_q <= 1'b0;
        else     stall_q <= mem_start & mem_internal & wait_on;
    end

    assign mem_ready = ~stall_q;
endmodule

// File: rtl/pmode_regs.sv
module pmode_regs
    import pmode_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG0_ADDR = 'h04,
    parameter logic [ADDR_W-1:0] REG1_ADDR = 'h05
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              wr_unlock,
    input  logic              flash_rewrite,
    input  logic              mem_start,
    input  logic              mem_internal,
    output logic              soft_rst_req,
    output logic              flash_blk_en,
    output logic              wdt_rst_sel,
    output logic              wait_en,
    output logic              mem_ready
);
    logic   hit0, hit1, wr_ok;
    mode1_t wr_val, m1;
    logic   wdata_unused;

    assign hit0  = (bus_addr == REG0_ADDR);
    assign hit1  = (bus_addr == REG1_ADDR);
    assign wr_ok = bus_wr & wr_unlock;

    assign wr_val.flash_blk = bus_wdata[FBLK_BIT];
    assign wr_val.wdt_reset = bus_wdata[WDT_BIT];
    assign wr_val.wait_on   = bus_wdata[WAIT_BIT];
    assign wdata_unused     = ^{bus_wdata[6:4], bus_wdata[1]};

    pmode_softrst u_srst (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_ok & hit0),
        .cmd_bit (bus_wdata[SRST_BIT]),
        .pulse   (soft_rst_req)
    );

    pmode_mode1 u_mode1 (
        .clk       (clk),
        .rst       (rst),
        .wr_hit    (wr_ok & hit1),
        .wr_val    (wr_val),
        .force_blk (flash_rewrite),
        .state     (m1)
    );

    pmode_waitgen u_wait (
        .clk          (clk),
        .rst          (rst),
        .wait_on      (m1.wait_on),
        .mem_start    (mem_start),
        .mem_internal (mem_internal),
        .mem_ready    (mem_ready)
    );

    assign flash_blk_en = m1.flash_blk;
    assign wdt_rst_sel  = m1.wdt_reset;
    assign wait_en      = m1.wait_on;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit0)      bus_rdata = REG0_RST;
            else if (hit1) bus_rdata = mode1_pack(m1);
        end
    end
endmodule

// File: rtl/pmode_regs_chk.sv
module pmode_regs_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG0_ADDR = 'h04,
    parameter logic [ADDR_W-1:0] REG1_ADDR = 'h05
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              wr_unlock,
    input logic              flash_rewrite,
    input logic              mem_start,
    input logic              mem_internal,
    input logic              soft_rst_req,
    input logic              wdt_rst_sel,
    input logic              wait_en,
    input logic              flash_blk_en,
    input logic              mem_ready
);
    p_srst_cause_r3: assert property (@(posedge clk) disable iff (rst)
        soft_rst_req |-> $past(bus_wr && wr_unlock && bus_addr == REG0_ADDR && bus_wdata[3]));

    p_reg0_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == REG0_ADDR) |-> bus_rdata == 8'h00);

    p_locked_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_unlock |=> ($stable(wait_en) && $stable(wdt_rst_sel) && !soft_rst_req));

    p_forced_r5: assert property (@(posedge clk) disable iff (rst)
        flash_rewrite |-> flash_blk_en);

    p_wdt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_sel |=> wdt_rst_sel);

    p_stall_cause_r7: assert property (@(posedge clk) disable iff (rst)
        !mem_ready |-> $past(mem_start && mem_internal && wait_en));

    p_no_stall_r7: assert property (@(posedge clk) disable iff (rst)
        !wait_en |=> mem_ready);

    p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == REG1_ADDR) |-> (bus_rdata[3] && bus_rdata[6:4] == 3'b000 && !bus_rdata[1]));

    p_idle_read_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == 8'h00);
endmodule

bind pmode_regs pmode_regs_chk #(
    .ADDR_W(ADDR_W), .REG0_ADDR(REG0_ADDR), .REG1_ADDR(REG1_ADDR)
) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .wr_unlock(wr_unlock), .flash_rewrite(flash_rewrite),
    .mem_start(mem_start), .mem_internal(mem_internal),
    .soft_rst_req(soft_rst_req), .wdt_rst_sel(wdt_rst_sel),
    .wait_en(wait_en), .flash_blk_en(flash_blk_en), .mem_ready(mem_ready)
);

// File: tb/pmode_regs_tb_top.sv
module pmode_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       bus_wr = 0, bus_rd = 0, wr_unlock = 0, flash_rewrite = 0;
    logic       mem_start = 0, mem_internal = 0;
    logic       soft_rst_req, flash_blk_en, wdt_rst_sel, wait_en, mem_ready;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic m_fbe = 0, m_wdt = 0, m_wait = 0;

    always #2.5 clk = ~clk;

    pmode_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .wr_unlock(wr_unlock), .flash_rewrite(flash_rewrite),
        .mem_start(mem_start), .mem_internal(mem_internal),
        .soft_rst_req(soft_rst_req), .flash_blk_en(flash_blk_en),
        .wdt_rst_sel(wdt_rst_sel), .wait_en(wait_en), .mem_ready(mem_ready)
    );

    function automatic logic [7:0] exp_reg1();
        return {m_wait, 3'b000, 1'b1, m_wdt, 1'b0, m_fbe | flash_rewrite};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_read(logic [7:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 check(req, bus_rdata, exp);
        bus_rd = 0;
        #0.5 check("R9 idle", bus_rdata, 8'h00);
    endtask

    task automatic check_outs(string req);
        check(req, {4'b0, flash_blk_en, wdt_rst_sel, wait_en, soft_rst_req},
              {4'b0, m_fbe | flash_rewrite, m_wdt, m_wait, 1'b0});
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d, logic unl);
        logic acc;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1; wr_unlock = unl;
        @(negedge clk);
        bus_wr = 0; wr_unlock = 0;
        acc = unl;
        if (acc && a == 8'h05) begin
            m_fbe  = flash_rewrite ? 1'b1 : d[0];
            m_wdt  = m_wdt | d[2];
            m_wait = d[7];
        end
        if (acc && a == 8'h04 && d[3]) begin
            check("R3 pulse", {7'b0, soft_rst_req}, 8'h01);
            @(negedge clk);
            check("R3 pulse width", {7'b0, soft_rst_req}, 8'h00);
        end else begin
            check(unl ? "R9 no pulse" : "R2 no pulse", {7'b0, soft_rst_req}, 8'h00);
        end
    endtask

    task automatic mem_access(logic internal);
        @(negedge clk);
        mem_start = 1; mem_internal = internal;
        #1 check("R7 ready in start cycle", {7'b0, mem_ready}, 8'h01);
        @(negedge clk);
        mem_start = 0; mem_internal = 0;
        check("R7 wait cycle", {7'b0, mem_ready}, {7'b0, !(internal && m_wait)});
        @(negedge clk);
        check("R7 ready after", {7'b0, mem_ready}, 8'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check_outs("R1 outputs");
        check("R1 ready", {7'b0, mem_ready}, 8'h01);
        do_read(8'h04, 8'h00, "R1 reg0");
        do_read(8'h05, 8'h08, "R1 reg1");
        // R2 locked writes
        do_write(8'h05, 8'hFF, 0);
        do_read(8'h05, exp_reg1(), "R2 locked reg1");
        do_write(8'h04, 8'h08, 0);
        // R3 software reset
        do_write(8'h04, 8'hFF, 1);
        do_read(8'h04, 8'h00, "R3 reg0 reads zero");
        // R4 / R8
        do_write(8'h05, 8'h7B, 1);
        do_read(8'h05, exp_reg1(), "R4 R8 reg1 set");
        check_outs("R4 outputs");
        do_write(8'h05, 8'h00, 1);
        do_read(8'h05, exp_reg1(), "R4 clear, R6 sticky");
        check_outs("R6 outputs");
        // R5 forced by rewrite mode
        @(negedge clk); flash_rewrite = 1;
        #1 check_outs("R5 immediate");
        do_write(8'h05, 8'h00, 1);
        do_read(8'h05, exp_reg1(), "R5 write zero ignored");
        @(negedge clk); flash_rewrite = 0; m_fbe = 1;
        #1 check_outs("R5 held after rewrite");
        do_write(8'h05, 8'h00, 1);
        check_outs("R5 cleared by write");
        // R7 wait generator
        mem_access(1);
        do_write(8'h05, 8'h80, 1);
        check_outs("R7 wait_en");
        mem_access(1);
        mem_access(0);
        // R9 other addresses
        do_write(8'h06, 8'hFF, 1);
        do_read(8'h06, 8'h00, "R9 other addr");
        do_read(8'h05, exp_reg1(), "R9 reg1 untouched");
        // random phase
        for (int i = 0; i < 300; i++) begin
            logic [7:0] a, d;
            int sel = $urandom_range(0, 3);
            a = (sel == 0) ? 8'h04 : (sel == 3) ? 8'($urandom) : 8'h05;
            d = 8'($urandom);
            do_write(a, d, 1'($urandom));
            do_read(8'h05, exp_reg1(), "R2 R4 R6 R8 random reg1");
            check_outs("R2 R6 R7 random outputs");
            if (i % 20 == 0) mem_access(1'($urandom));
        end
        // R6 cleared only by reset
        do_write(8'h05, 8'h04, 1);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        m_fbe = 0; m_wdt = 0; m_wait = 0;
        check_outs("R6 R1 cleared by reset");
        do_read(8'h05, 8'h08, "R1 reg1 after reset");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule